// File: doc/BRIEF.md
# Synchronous Burst SRAM Command Engine

This block models a single-port synchronous burst SRAM with a 32-bit word divided into four byte lanes. On every rising clock edge it samples its control inputs and decodes them into exactly one operation. The operations are: start a read or write burst at an external address, continue the running burst, deselect, continue a deselect, stall the edge, or power down. A continue cycle reuses the read/write type that was chosen when the burst started. It steps the low two address bits forward and wraps them within a group of four words.

Read data passes through one output register and appears on the bus in the cycle after the edge that selected it. Output enable and the power-down input gate the bus without waiting for a clock edge. Write data is taken from the bus at the same edge as the write command. The bus is presented as an input word, an output word and a drive-enable signal, so the tri-state pad sits outside the block. Memory contents are not cleared by reset.

Top module: `sbs_sram`

## Requirements
- R1: The chip is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. When `cont_burst`=0 and any select is inactive, the edge is a deselect: nothing is read or written, the burst ends, and `dq_oe` is 0 from the following cycle.
- R2: When `cont_burst`=0 and the chip is selected, `addr` is loaded. With `read_not_write`=1, the word at `addr` appears on `dq_out` in the next cycle, with `dq_oe`=1 when `out_en_n`=0. With `read_not_write`=0, `dq_in` is written at `addr` on that edge.
- R3: When `cont_burst`=1 during a burst, the burst keeps its starting type and ignores `read_not_write` and the three selects. Address bits [1:0] step by +1 modulo 4 on each continue cycle, and the upper bits stay fixed.
- R4: When `cont_burst`=1 with no burst running (after reset, a deselect or a power-down), the edge is a continue-deselect: nothing is accessed and `dq_oe` stays 0.
- R5: `lane_wr_n[k]`=0 enables a write of byte lane k, where lane k is `dq_in[8k+7:8k]`. Lanes whose bit is 1 keep their old value, and any mix of lanes may be enabled together.
- R6: A write cycle (start or continue) with `lane_wr_n`=4'b1111 changes no memory byte. A continue cycle of this kind still advances the burst address.
- R7: During a read burst, `out_en_n`=1 sets `dq_oe` to 0 in that same cycle (dummy read). Addresses keep advancing, so a later cycle with `out_en_n`=0 shows the current burst word.
- R8: When `clk_en_n`=1, the edge is ignored: no write is performed, the address is held, and the bus keeps its drive state and data.
- R9: `doze`=1 sets `dq_oe` to 0 at once, blocks every access at the edge, and ends any burst, so a following continue cycle is a continue-deselect.
- R10: During a write burst `dq_oe` is 0, even when `out_en_n`=0.
- R11: The synchronous active-high `rst` leaves the block deselected with `dq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| doze | input | 1 | Power-down, active high, overrides all else |
| clk_en_n | input | 1 | Clock enable, active low (1 = stall edge) |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| cont_burst | input | 1 | 0 = load address and start, 1 = continue |
| read_not_write | input | 1 | Burst type at start: 1 read, 0 write |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | 6 | Word address for a burst start |
| dq_in | input | 32 | Write data from the bus |
| dq_out | output | 32 | Read data toward the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
On every cycle, the in-line assertions check several properties of the control logic. Deselects and power-down never issue an access. Stalls freeze the address, burst state and drive state. Continue cycles step only the two low address bits. A write burst never drives the bus, and an all-high lane mask never writes. Other behaviours are visible only in the bench scenarios, which compare the bus against a behavioural model every cycle: the data actually read back after partial-lane writes, aborted writes and stalled writes, and the burst wrap order. The scenarios also cover the dummy-read window, where the bus goes quiet while the address keeps moving.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR
    } burst_st_e;

    typedef enum logic [2:0] {
        OP_SLEEP,
        OP_STALL,
        OP_DESEL,
        OP_CONT_DESEL,
        OP_RD_START,
        OP_RD_NEXT,
        OP_WR_START,
        OP_WR_NEXT
    } op_e;

    typedef struct packed {
        logic doze;
        logic clk_en_n;
        logic cont;
        logic rnw;
        logic selected;
    } cmd_t;

    function automatic logic chip_selected(logic a_n, logic b, logic c_n);
        return ~a_n & b & ~c_n;
    endfunction

    function automatic op_e classify(cmd_t c, burst_st_e st);
        op_e r;
        if (c.doze)
            r = OP_SLEEP;
        else if (c.clk_en_n)
            r = OP_STALL;
        else if (!c.cont)
            r = !c.selected ? OP_DESEL : (c.rnw ? OP_RD_START : OP_WR_START);
        else if (st == ST_RD)
            r = OP_RD_NEXT;
        else if (st == ST_WR)
            r = OP_WR_NEXT;
        else
            r = OP_CONT_DESEL;
        return r;
    endfunction

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 4,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              doze,
    input  logic              clk_en_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              cont_burst,
    input  logic              read_not_write,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              rd_en,
    output logic [LANES-1:0]  wr_lane,
    output logic              rd_valid
);

    burst_st_e         st_q;
    logic [ADDR_W-1:0] cur_q;
    logic              rd_valid_q;
    cmd_t              cmd;
    op_e               op;
    logic [BURST_W-1:0] low_inc;

    always_comb begin
        cmd.doze     = doze;
        cmd.clk_en_n = clk_en_n;
        cmd.cont     = cont_burst;
        cmd.rnw      = read_not_write;
        cmd.selected = chip_selected(sel_a_n, sel_b, sel_c_n);
        op           = classify(cmd, st_q);
        low_inc      = cur_q[BURST_W-1:0] + BURST_W'(1);
        if (op == OP_RD_START || op == OP_WR_START)
            acc_addr = addr_in;
        else
            acc_addr = {cur_q[ADDR_W-1:BURST_W], low_inc};
        rd_en   = (op == OP_RD_START) || (op == OP_RD_NEXT);
        wr_lane = ((op == OP_WR_START) || (op == OP_WR_NEXT)) ? ~lane_wr_n : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cur_q      <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            case (op)
                OP_STALL: ;
                OP_RD_START: begin
                    st_q       <= ST_RD;
                    cur_q      <= acc_addr;
                    rd_valid_q <= 1'b1;
                end
                OP_WR_START: begin
                    st_q       <= ST_WR;
                    cur_q      <= acc_addr;
                    rd_valid_q <= 1'b0;
                end
                OP_RD_NEXT: begin
                    cur_q      <= acc_addr;
                    rd_valid_q <= 1'b1;
                end
                OP_WR_NEXT: begin
                    cur_q      <= acc_addr;
                    rd_valid_q <= 1'b0;
                end
                default: begin
                    st_q       <= ST_IDLE;
                    rd_valid_q <= 1'b0;
                end
            endcase
        end
    end

    assign rd_valid = rd_valid_q;

    // R1: a deselect edge issues no access
    a_r1_desel_no_access: assert property (@(posedge clk) disable iff (rst)
        (!doze && !clk_en_n && !cont_burst && !(~sel_a_n & sel_b & ~sel_c_n))
        |-> (!rd_en && wr_lane == '0));

    // R3: continue cycles step only the low burst bits, modulo 4
    a_r3_wrap_step: assert property (@(posedge clk) disable iff (rst)
        (!doze && !clk_en_n && cont_burst && st_q != ST_IDLE)
        |=> (cur_q[ADDR_W-1:BURST_W] == $past(cur_q[ADDR_W-1:BURST_W])
             && cur_q[BURST_W-1:0] == BURST_W'($past(cur_q[BURST_W-1:0]) + 1'b1)));

    // R4: continue with no burst running is inert
    a_r4_cont_desel: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && cont_burst) |-> (!rd_en && wr_lane == '0));

    // R6: an all-high lane mask never writes
    a_r6_abort: assert property (@(posedge clk) disable iff (rst)
        (&lane_wr_n) |-> (wr_lane == '0));

    // R8: a stalled edge writes nothing and freezes state
    a_r8_stall_nowrite: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |-> (wr_lane == '0));
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (clk_en_n && !doze) |=> ($stable(cur_q) && $stable(rd_valid_q) && $stable(st_q)));

    // R9: power-down blocks access and ends the burst
    a_r9_sleep: assert property (@(posedge clk) disable iff (rst)
        doze |-> (!rd_en && wr_lane == '0));
    a_r9_sleep_end: assert property (@(posedge clk) disable iff (rst)
        doze |=> (st_q == ST_IDLE && !rd_valid_q));

    // R10: a write burst never leaves read data pending
    a_r10_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WR) |-> !rd_valid_q);

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    rd_en,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_lane[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst)
                rd_q <= '0;
            else if (rd_en)
                rd_q <= mem[addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;

        // R5: a lane write and a read never share an edge
        a_r5_lane_excl: assert property (@(posedge clk) disable iff (rst)
            wr_lane[g] |-> !rd_en);
    end

endmodule

// File: rtl/sbs_sram.sv
module sbs_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    parameter int LANES   = 4,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              doze,
    input  logic              clk_en_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              cont_burst,
    input  logic              read_not_write,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam int LANE_W = DATA_W / LANES;

    logic [ADDR_W-1:0] acc_addr;
    logic              rd_en;
    logic [LANES-1:0]  wr_lane;
    logic              rd_valid;

    sbs_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .BURST_W(BURST_W)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .doze          (doze),
        .clk_en_n      (clk_en_n),
        .sel_a_n       (sel_a_n),
        .sel_b         (sel_b),
        .sel_c_n       (sel_c_n),
        .cont_burst    (cont_burst),
        .read_not_write(read_not_write),
        .lane_wr_n     (lane_wr_n),
        .addr_in       (addr),
        .acc_addr      (acc_addr),
        .rd_en         (rd_en),
        .wr_lane       (wr_lane),
        .rd_valid      (rd_valid)
    );

    sbs_array #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_array (
        .clk    (clk),
        .rst    (rst),
        .addr   (acc_addr),
        .rd_en  (rd_en),
        .wr_lane(wr_lane),
        .wdata  (dq_in),
        .rdata  (dq_out)
    );

    assign dq_oe = rd_valid & ~out_en_n & ~doze;

    // R11: reset leaves nothing pending on the bus
    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |=> !rd_valid);

endmodule

// File: tb/sim_sbs_sram.sv
module sim_sbs_sram;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        doze = 1'b0, clk_en_n = 1'b0;
    logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic        cont_burst = 1'b0, read_not_write = 1'b1;
    logic [3:0]  lane_wr_n = 4'hF;
    logic        out_en_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] dq_in = '0;
    logic [31:0] dq_out;
    logic        dq_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural reference state
    logic [31:0] m_mem [64];
    bit   [3:0]  m_known [64];
    int          m_st = 0;      // 0 idle, 1 read, 2 write
    int          m_addr = 0;
    bit          m_drv = 1'b0;
    logic [31:0] m_rd = '0;
    bit   [3:0]  m_rk = '0;

    always #5 clk = ~clk;

    sbs_sram u0 (
        .clk(clk), .rst(rst), .doze(doze), .clk_en_n(clk_en_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .cont_burst(cont_burst), .read_not_write(read_not_write),
        .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic model_access(int a);
        m_addr = a;
        if (m_st == 1) begin
            m_rd  = m_mem[a];
            m_rk  = m_known[a];
            m_drv = 1'b1;
        end else begin
            m_drv = 1'b0;
            for (int l = 0; l < 4; l++) begin
                if (!lane_wr_n[l]) begin
                    m_mem[a][l*8 +: 8] = dq_in[l*8 +: 8];
                    m_known[a][l] = 1'b1;
                end
            end
        end
    endtask

    task automatic model_edge();
        if (doze) begin
            m_st = 0; m_drv = 1'b0;
        end else if (clk_en_n) begin
        end else if (!cont_burst) begin
            if (!sel_a_n && sel_b && !sel_c_n) begin
                m_st = read_not_write ? 1 : 2;
                model_access(int'(addr));
            end else begin
                m_st = 0; m_drv = 1'b0;
            end
        end else if (m_st == 0) begin
            m_drv = 1'b0;
        end else begin
            model_access((m_addr & ~3) | ((m_addr + 1) & 3));
        end
    endtask

    task automatic check_bus(string tag);
        bit exp_oe;
        bit bad;
        exp_oe = m_drv && !out_en_n && !doze;
        bad = (dq_oe !== exp_oe);
        if (exp_oe)
            for (int l = 0; l < 4; l++)
                if (m_rk[l] && dq_out[l*8 +: 8] !== m_rd[l*8 +: 8]) bad = 1'b1;
        n_tests++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s t=%0t actual oe=%0b data=%h expected oe=%0b data=%h lanes=%b",
                     tag, $time, dq_oe, dq_out, exp_oe, m_rd, m_rk);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input string tag, input bit dz, input bit cen,
                        input bit sa, input bit sb, input bit sc, input bit cont,
                        input bit rnw, input bit [3:0] lw, input bit oen,
                        input bit [5:0] a, input bit [31:0] wd);
        doze = dz; clk_en_n = cen; sel_a_n = sa; sel_b = sb; sel_c_n = sc;
        cont_burst = cont; read_not_write = rnw; lane_wr_n = lw;
        out_en_n = oen; addr = a; dq_in = wd;
        #1;
        check_bus(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic wrb(string t, bit [5:0] a, bit [3:0] lw, bit [31:0] d);
        step(t, 0, 0, 0, 1, 0, 0, 0, lw, 0, a, d);
    endtask
    task automatic rdb(string t, bit [5:0] a, bit oen);
        step(t, 0, 0, 0, 1, 0, 0, 1, 4'hF, oen, a, 32'h0);
    endtask
    // continue with selects inactive and a random type bit: both must be ignored
    task automatic nx(string t, bit rnw, bit [3:0] lw, bit oen, bit [31:0] d);
        step(t, 0, 0, 1, 0, 1, 1, rnw, lw, oen, 6'h3F, d);
    endtask
    task automatic ds(string t, bit sa, bit sb, bit sc);
        step(t, 0, 0, sa, sb, sc, 0, 1, 4'hF, 0, 6'h00, 32'h0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_mem[i] = '0; m_known[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_bus("R11");               // reset state: quiet bus
        nx("R11", 1, 4'h0, 0, 32'h0);   // continue after reset is inert
        check_bus("R11");

        // R2/R3: write burst from 5 wraps 5,6,7,4; selects/type ignored on continue
        wrb("R2", 6'd5, 4'h0, 32'hA0A0_0005);
        nx("R3", 1, 4'h0, 0, 32'hA1A1_0006);
        nx("R3", 1, 4'h0, 0, 32'hA2A2_0007);
        nx("R3", 0, 4'h0, 0, 32'hA3A3_0004);
        ds("R1", 1, 1, 0);
        // R2/R3: read the same group, with R10 visible while writing above
        rdb("R2", 6'd5, 0);
        nx("R3", 0, 4'h0, 0, 32'h0);
        nx("R3", 0, 4'h0, 0, 32'h0);
        nx("R3", 1, 4'h0, 0, 32'h0);
        nx("R3", 1, 4'hF, 0, 32'h0);
        ds("R1", 0, 0, 0);
        ds("R1", 0, 1, 0);

        // R5: partial lanes
        wrb("R5", 6'd12, 4'h0, 32'hFFFF_FFFF);
        nx("R5", 1, 4'h0, 0, 32'h0000_0000);
        wrb("R5", 6'd12, 4'b1010, 32'h1122_3344);
        nx("R5", 1, 4'b0101, 0, 32'h5566_7788);
        ds("R1", 0, 1, 1);
        rdb("R5", 6'd12, 0);
        nx("R5", 0, 4'h0, 0, 32'h0);
        nx("R5", 0, 4'h0, 0, 32'h0);
        ds("R1", 1, 1, 0);

        // R6: aborted writes, address still advances
        wrb("R6", 6'd20, 4'h0, 32'h0000_0001);
        nx("R6", 1, 4'h0, 0, 32'h0000_0002);
        nx("R6", 1, 4'h0, 0, 32'h0000_0003);
        nx("R6", 1, 4'h0, 0, 32'h0000_0004);
        wrb("R6", 6'd20, 4'hF, 32'hDEAD_BEEF);
        nx("R6", 1, 4'hF, 0, 32'hDEAD_BEEF);
        nx("R6", 1, 4'b0011, 0, 32'hCAFE_0000);
        ds("R6", 1, 1, 0);
        rdb("R6", 6'd20, 0);
        nx("R6", 0, 4'h0, 0, 32'h0);
        nx("R6", 0, 4'h0, 0, 32'h0);
        nx("R6", 0, 4'h0, 0, 32'h0);
        nx("R6", 0, 4'h0, 0, 32'h0);

        // R7: dummy read window
        rdb("R7", 6'd4, 0);
        nx("R7", 0, 4'h0, 1, 32'h0);
        nx("R7", 0, 4'h0, 1, 32'h0);
        nx("R7", 0, 4'h0, 0, 32'h0);
        nx("R7", 0, 4'h0, 0, 32'h0);

        // R8: stall in a read keeps the bus driven with the same word
        rdb("R8", 6'd6, 0);
        step("R8", 0, 1, 0, 1, 0, 0, 0, 4'h0, 0, 6'd30, 32'h1234_5678);
        step("R8", 0, 1, 1, 0, 1, 1, 1, 4'h0, 0, 6'd31, 32'h0);
        nx("R8", 0, 4'h0, 0, 32'h0);
        ds("R8", 1, 1, 0);
        // R8: stall in a write leaves memory and address alone
        wrb("R8", 6'd28, 4'h0, 32'hAAAA_AAAA);
        step("R8", 0, 1, 0, 1, 0, 0, 0, 4'h0, 0, 6'd30, 32'hBBBB_BBBB);
        nx("R8", 1, 4'h0, 0, 32'hCCCC_CCCC);
        ds("R8", 1, 1, 0);
        rdb("R8", 6'd28, 0);
        nx("R8", 0, 4'h0, 0, 32'h0);
        nx("R8", 0, 4'h0, 0, 32'h0);

        // R4: continue-deselect after a deselect
        ds("R4", 1, 1, 0);
        nx("R4", 0, 4'h0, 0, 32'hFFFF_FFFF);
        nx("R4", 1, 4'h0, 0, 32'h0);
        rdb("R4", 6'd29, 0);
        nx("R4", 0, 4'h0, 0, 32'h0);

        // R1: deselect mid-read by each select
        rdb("R1", 6'd4, 0);
        ds("R1", 0, 1, 1);
        nx("R1", 1, 4'h0, 0, 32'h0);
        rdb("R1", 6'd5, 0);
        ds("R1", 1, 1, 0);
        nx("R1", 1, 4'h0, 0, 32'h0);

        // R9: power-down mid-read, then continue is inert, and a write is blocked
        rdb("R9", 6'd5, 0);
        step("R9", 1, 0, 1, 0, 1, 1, 1, 4'h0, 0, 6'd0, 32'h0);
        nx("R9", 1, 4'h0, 0, 32'h0);
        step("R9", 1, 0, 0, 1, 0, 0, 0, 4'h0, 0, 6'd28, 32'h0BAD_0BAD);
        nx("R9", 0, 4'h0, 0, 32'h0BAD_0BAD);
        rdb("R9", 6'd28, 0);
        nx("R9", 0, 4'h0, 0, 32'h0);
        step("R9", 1, 1, 0, 1, 0, 0, 1, 4'hF, 0, 6'd0, 32'h0);
        ds("R9", 1, 1, 0);

        // R10: write burst with output enable held low
        rdb("R10", 6'd12, 0);
        ds("R10", 1, 1, 0);
        wrb("R10", 6'd40, 4'h0, 32'h4040_4040);
        nx("R10", 1, 4'h0, 0, 32'h4141_4141);
        nx("R10", 1, 4'h0, 0, 32'h4242_4242);
        ds("R10", 1, 1, 0);
        rdb("R10", 6'd40, 0);
        nx("R10", 0, 4'h0, 0, 32'h0);
        nx("R10", 0, 4'h0, 0, 32'h0);
        nx("R10", 0, 4'h0, 0, 32'h0);
        ds("R10", 1, 1, 0);

        // R11: reset mid-burst
        rdb("R11", 6'd40, 0);
        rst = 1'b1;
        @(posedge clk);
        m_st = 0; m_drv = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check_bus("R11");
        nx("R11", 0, 4'h0, 0, 32'h0);
        check_bus("R11");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule